// File: doc/BRIEF.md
# Sixteen-Way 4x4 Block Difference Engine

This block scores one 16x16 candidate block against the current block. It produces the sixteen sums of absolute pixel differences that belong to its 4x4 sub-blocks. The block takes one row per beat: sixteen candidate pixels and sixteen current pixels arrive in parallel. A row of sixteen difference lanes turns them into sixteen absolute differences. Each group of four neighbouring lanes is added together and accumulated across four rows. The result of that accumulation is one sub-block score.

A row counter tracks the position in the block. At the last row of each four-row band it steers every group's finished total into the holding register for that band, then restarts the accumulator. After sixteen accepted rows all sixteen scores are held, and a one-cycle strobe announces them. Several instances can work side by side, one per candidate of a search step. Fetching pixels, merging scores into larger partitions and choosing the best candidate happen elsewhere.

Top module: `sad4x4_pu`

## Requirements
- R1: After reset, `sadValid` is low and every score field of `sadFlat` reads zero.
- R2: Score k, held at `sadFlat[12*k +: 12]` with k = 4*band + group, is the sum of |cand - cur| over its sixteen pixels. Band b covers accepted rows 4b to 4b+3. Group g covers lanes 4g to 4g+3. Lane i is bits `[8*i+7 : 8*i]` of `candRow` and `curRow`, and pixels are unsigned.
- R3: `sadValid` is high for exactly one cycle: the cycle after the sixteenth accepted row of a block. It is low in every other cycle.
- R4: A cycle with `inValid` low is ignored whatever the pixel buses carry. Row position, partial sums and outputs are unchanged, so idle gaps may fall anywhere inside a block.
- R5: The four scores of band b change only at the edge that accepts the last row of that band. They hold their value at all other times.
- R6: Partial sums restart at every band, so no difference leaks into the next band or the next block.
- R7: A row accepted in the same cycle that `sadValid` is high is the first row of the next block. Blocks may follow each other with no gap.
- R8: The full-scale case (every difference 255) gives exactly 4080 in every score, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Row beat qualifier |
| candRow | input | 128 | Sixteen candidate pixels of the current row |
| curRow | input | 128 | Sixteen current-block pixels of the current row |
| sadValid | output | 1 | One-cycle strobe: all sixteen scores are final |
| sadFlat | output | 192 | Sixteen 12-bit sub-block scores, score k at bits 12k+11:12k |

## Verification
Two functions can fall in the same cycle: presenting finished scores, and accepting the first row of the following block. The bench provokes this by sending two blocks back to back with no idle cycle between them. It checks that, while the strobe is high, the outputs still carry the first block's scores. It also checks that band 0 keeps the first block's values until the fourth row of the second block is accepted, and that the second block's scores come out exact.

// File: rtl/sad4x4_pkg.sv
package sad4x4_pkg;
  localparam int PIX_W     = 8;
  localparam int LANES     = 16;
  localparam int GRP_LANES = 4;
  localparam int NUM_GRP   = LANES / GRP_LANES;
  localparam int ROWS      = 16;
  localparam int BAND_ROWS = 4;
  localparam int NUM_BAND  = ROWS / BAND_ROWS;
  localparam int NUM_SAD   = NUM_GRP * NUM_BAND;
  localparam int SAD_W     = PIX_W + $clog2(GRP_LANES * BAND_ROWS);
  localparam int GSUM_W    = PIX_W + $clog2(GRP_LANES);
  localparam int ROW_W     = $clog2(ROWS);
  localparam int PHASE_W   = $clog2(BAND_ROWS);
  localparam int BAND_W    = $clog2(NUM_BAND);
  localparam int SAD_MAX   = ((1 << PIX_W) - 1) * GRP_LANES * BAND_ROWS;

  typedef struct packed {
    logic              accEn;
    logic              bandEnd;
    logic [BAND_W-1:0] bandSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/sad4x4_absdiff.sv
module sad4x4_absdiff
  import sad4x4_pkg::*;
(
  input  logic [PIX_W-1:0] pixA,
  input  logic [PIX_W-1:0] pixB,
  output logic [PIX_W-1:0] diff
);
  always_comb begin
    if (pixA > pixB) diff = pixA - pixB;
    else             diff = pixB - pixA;
  end
endmodule

// File: rtl/sad4x4_ctrl.sv
module sad4x4_ctrl
  import sad4x4_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        sadValid
);
  localparam logic [ROW_W-1:0]   LAST_ROW   = ROW_W'(ROWS - 1);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(BAND_ROWS - 1);

  logic [ROW_W-1:0] rowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowCnt <= '0;
    end else if (inValid) begin
      if (rowCnt == LAST_ROW) rowCnt <= '0;
      else                    rowCnt <= rowCnt + ROW_W'(1);
    end
  end

  always_comb begin
    strobe.accEn   = inValid;
    strobe.bandEnd = inValid && (rowCnt[PHASE_W-1:0] == LAST_PHASE);
    strobe.bandSel = rowCnt[ROW_W-1:PHASE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sadValid <= 1'b0;
    else       sadValid <= inValid && (rowCnt == LAST_ROW);
  end
endmodule

// File: rtl/sad4x4_dp.sv
module sad4x4_dp
  import sad4x4_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [LANES*PIX_W-1:0]   candRow,
  input  logic [LANES*PIX_W-1:0]   curRow,
  output logic [NUM_SAD*SAD_W-1:0] sadFlat
);
  logic [PIX_W-1:0] laneDiff [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_pe
    sad4x4_absdiff u_pe (
      .pixA (candRow[i*PIX_W +: PIX_W]),
      .pixB (curRow[i*PIX_W +: PIX_W]),
      .diff (laneDiff[i])
    );
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [GSUM_W-1:0] grpSum;
    logic [SAD_W-1:0]  acc;
    logic [SAD_W-1:0]  bandTotal;

    always_comb begin
      grpSum = '0;
      for (int j = 0; j < GRP_LANES; j++) begin
        grpSum = grpSum + GSUM_W'(laneDiff[g*GRP_LANES + j]);
      end
    end

    assign bandTotal = acc + SAD_W'(grpSum);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc <= '0;
      end else if (strobe.accEn) begin
        if (strobe.bandEnd) acc <= '0;
        else                acc <= bandTotal;
      end
    end

    for (genvar b = 0; b < NUM_BAND; b++) begin : g_band
      logic [SAD_W-1:0] hold;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          hold <= '0;
        end else if (strobe.bandEnd && (strobe.bandSel == BAND_W'(b))) begin
          hold <= bandTotal;
        end
      end

      assign sadFlat[(b*NUM_GRP + g)*SAD_W +: SAD_W] = hold;
    end
  end
endmodule

// File: rtl/sad4x4_pu.sv
module sad4x4_pu
  import sad4x4_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [LANES*PIX_W-1:0]   candRow,
  input  logic [LANES*PIX_W-1:0]   curRow,
  output logic                     sadValid,
  output logic [NUM_SAD*SAD_W-1:0] sadFlat
);
  ctrlStrobe_t strobe;

  sad4x4_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .sadValid (sadValid)
  );

  sad4x4_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .candRow (candRow),
    .curRow  (curRow),
    .sadFlat (sadFlat)
  );
endmodule

// File: rtl/sad4x4_chk.sv
module sad4x4_chk
  import sad4x4_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic                     sadValid,
  input logic [NUM_SAD*SAD_W-1:0] sadFlat
);
  logic [ROW_W-1:0] beatSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        beatSeen <= '0;
    else if (inValid) beatSeen <= (beatSeen == ROW_W'(ROWS - 1)) ? '0 : beatSeen + ROW_W'(1);
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sadValid |=> !sadValid); // R3

  AST_STROBE_ON_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && beatSeen == ROW_W'(ROWS - 1)) |=> sadValid); // R3

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !sadValid); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(sadFlat)); // R4

  for (genvar k = 0; k < NUM_SAD; k++) begin : g_rng
    AST_SAD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      sadFlat[k*SAD_W +: SAD_W] <= SAD_W'(SAD_MAX)); // R8
  end
endmodule

bind sad4x4_pu sad4x4_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .sadValid (sadValid),
  .sadFlat  (sadFlat)
);

// File: tb/sad4x4_pu_tb.sv
module sad4x4_pu_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] candRow = '0;
  logic [127:0] curRow = '0;
  logic         sadValid;
  logic [191:0] sadFlat;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] cand [16][16];
  logic [7:0] cur  [16][16];
  int expSad [16];
  int prevSad [16];

  always #2 clk = ~clk;

  sad4x4_pu u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .candRow(candRow), .curRow(curRow),
    .sadValid(sadValid), .sadFlat(sadFlat)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void computeExp();
    for (int k = 0; k < 16; k++) begin
      int b = k / 4;
      int g = k % 4;
      expSad[k] = 0;
      for (int r = 4*b; r < 4*b + 4; r++)
        for (int l = 4*g; l < 4*g + 4; l++)
          expSad[k] += (cand[r][l] > cur[r][l]) ? int'(cand[r][l]) - int'(cur[r][l])
                                                : int'(cur[r][l]) - int'(cand[r][l]);
    end
  endfunction

  function automatic int sadOf(int k);
    return int'(sadFlat[12*k +: 12]);
  endfunction

  task automatic checkAll(string req, const ref int ref_vals [16]);
    for (int k = 0; k < 16; k++) check(req, sadOf(k), ref_vals[k]);
  endtask

  task automatic fillRandom();
    for (int r = 0; r < 16; r++)
      for (int l = 0; l < 16; l++) begin
        cand[r][l] = 8'($urandom);
        cur[r][l]  = 8'($urandom);
      end
  endtask

  task automatic putRow(int r);
    inValid = 1'b1;
    for (int l = 0; l < 16; l++) begin
      candRow[8*l +: 8] = cand[r][l];
      curRow[8*l +: 8]  = cur[r][l];
    end
  endtask

  task automatic putIdle();
    inValid = 1'b0;
    candRow = {$urandom, $urandom, $urandom, $urandom};
    curRow  = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic sendBlock();
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      if (r > 0) check("R3 strobe early", int'(sadValid), 0);
      putRow(r);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 strobe", int'(sadValid), 0);
    for (int k = 0; k < 16; k++) check("R1 score", sadOf(k), 0);
    for (int c = 0; c < 4; c++) begin
      putIdle();
      @(negedge clk);
      check("R4 idle strobe", int'(sadValid), 0);
    end
    for (int k = 0; k < 16; k++) check("R4 idle score", sadOf(k), 0);
  endtask

  task automatic t_random();
    fillRandom();
    computeExp();
    sendBlock();
    check("R3 strobe", int'(sadValid), 1);
    checkAll("R2 score", expSad);
    putIdle();
    @(negedge clk);
    check("R3 strobe drop", int'(sadValid), 0);
    checkAll("R5 held", expSad);
  endtask

  task automatic t_max();
    for (int r = 0; r < 16; r++)
      for (int l = 0; l < 16; l++) begin
        cand[r][l] = (l % 2 == 0) ? 8'd255 : 8'd0;
        cur[r][l]  = (l % 2 == 0) ? 8'd0 : 8'd255;
      end
    computeExp();
    sendBlock();
    check("R8 strobe", int'(sadValid), 1);
    for (int k = 0; k < 16; k++) check("R8 full scale", sadOf(k), 4080);
    putIdle();
  endtask

  task automatic t_band();
    for (int r = 0; r < 16; r++)
      for (int l = 0; l < 16; l++) begin
        cand[r][l] = 8'd77;
        cur[r][l]  = 8'd77;
      end
    cand[8][5]  = 8'd200;
    cur[11][7]  = 8'd10;
    computeExp();
    check("R6 model", expSad[9], 123 + 67);
    sendBlock();
    check("R6 strobe", int'(sadValid), 1);
    checkAll("R6 isolation", expSad);
    putIdle();
  endtask

  task automatic t_gaps();
    fillRandom();
    computeExp();
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      putRow(r);
      for (int c = 0; c < (r % 3); c++) begin
        @(negedge clk);
        check("R4 gap strobe", int'(sadValid), 0);
        putIdle();
      end
    end
    @(negedge clk);
    check("R4 strobe after gaps", int'(sadValid), 1);
    checkAll("R4 score with gaps", expSad);
    putIdle();
    @(negedge clk);
  endtask

  task automatic t_backtoback();
    fillRandom();
    computeExp();
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      putRow(r);
    end
    for (int k = 0; k < 16; k++) prevSad[k] = expSad[k];
    fillRandom();
    computeExp();
    @(negedge clk);
    check("R7 strobe with new row", int'(sadValid), 1);
    checkAll("R7 first block", prevSad);
    putRow(0);
    for (int r = 1; r < 16; r++) begin
      @(negedge clk);
      if (r == 3) begin
        for (int k = 0; k < 4; k++) check("R5 band0 held", sadOf(k), prevSad[k]);
      end
      if (r == 4) begin
        for (int k = 0; k < 4; k++) check("R5 band0 updated", sadOf(k), expSad[k]);
        for (int k = 4; k < 16; k++) check("R5 band1-3 held", sadOf(k), prevSad[k]);
      end
      check("R3 no strobe mid block", int'(sadValid), 0);
      putRow(r);
    end
    @(negedge clk);
    check("R7 second strobe", int'(sadValid), 1);
    checkAll("R7 second block", expSad);
    putIdle();
    @(negedge clk);
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    putIdle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_random();
    t_max();
    t_band();
    t_gaps();
    t_backtoback();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule